// File: doc/BRIEF.md
# Adaptive Phase Switch Controller

This block decides the moment at which the current signal phase of a two-arm intersection should end. It receives the queued car counts of both arms, the running phase timer, a lower and an upper time bound for each arm's green phase, a separate pair of bounds for the protected left-turn phase, an upper bound for the pedestrian phase, a weight and an offset for each arm, the arm the current phase serves and the phase type. From these it produces a registered one-cycle switch request, together with a matching pulse that clears the external phase timer.

During a green phase a signed balance value is formed for the served arm: its weight times its own queue, plus its offset, minus the queue on the other arm. Between the lower and upper bounds the phase is kept only while the served queue is non-empty and the balance is positive. The left-turn phase ends when the served queue has not moved for a fixed number of timer units. After each request the controller stays silent until either car count changes. This stops a second request from being raised against the same traffic picture.

Top module: `phase_switch_ctl`

## Requirements
- R1: For arm k the balance is f_k = wt_k·n_own + bias_k − n_other, evaluated signed and wide enough (CNT_W+ALPHA_W+2 bits) that it never wraps. "f ≤ 0" means that the sign bit is set or the value is zero.
- R2: With phase = 2'b00 (green), no request is raised while tmr is below the minimum of the served arm (fav_arm = 0 serves arm 1, fav_arm = 1 serves arm 2).
- R3: With phase = 2'b00, an armed controller raises a request once tmr is at or above the maximum of the served arm, whatever the counts are.
- R4: With phase = 2'b00 and the minimum ≤ tmr < the maximum, an armed controller raises a request if and only if the served count is 0 or its balance f ≤ 0.
- R5: With phase = 2'b01 (left turn), no request is raised while tmr < min_left, and one is forced once tmr ≥ max_left.
- R6: With phase = 2'b01 and min_left ≤ tmr < max_left, a request is raised when the served count has stayed the same for STALL_T (default 5) timer units, that is when tmr minus the timer value at its last change is at least STALL_T. A cycle in which the count changes never counts as stalled.
- R7: With phase = 2'b10 (pedestrian), an armed controller raises a request if and only if tmr ≥ max_ped.
- R8: With phase = 2'b11 (idle), no request is ever raised.
- R9: sw_req is registered. It rises one clock edge after the deciding inputs are presented and lasts exactly one cycle. tmr_clr is high in exactly the same cycles.
- R10: After a request, no further request is raised until cnt_a1 or cnt_a2 differs from the values held at the request. The controller re-arms on that edge, and a request can follow at the next edge.
- R11: While rst_n is low, and on the first cycle after it, sw_req and tmr_clr are 0. The controller comes out of reset armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a1 | input | CNT_W | Queued cars on arm 1 |
| cnt_a2 | input | CNT_W | Queued cars on arm 2 |
| tmr | input | TMR_W | Time spent in the current phase |
| min_a1 | input | TMR_W | Minimum green time, arm 1 |
| max_a1 | input | TMR_W | Maximum green time, arm 1 |
| min_a2 | input | TMR_W | Minimum green time, arm 2 |
| max_a2 | input | TMR_W | Maximum green time, arm 2 |
| min_left | input | TMR_W | Minimum left-turn time |
| max_left | input | TMR_W | Maximum left-turn time |
| max_ped | input | TMR_W | Pedestrian phase length |
| wt_a1 | input | ALPHA_W | Weight of arm 1 |
| wt_a2 | input | ALPHA_W | Weight of arm 2 |
| bias_a1 | input | CNT_W | Offset of arm 1 |
| bias_a2 | input | CNT_W | Offset of arm 2 |
| fav_arm | input | 1 | Served arm: 0 is arm 1, 1 is arm 2 |
| phase | input | 2 | 00 green, 01 left turn, 10 pedestrian, 11 idle |
| sw_req | output | 1 | One-cycle switch request |
| tmr_clr | output | 1 | One-cycle phase timer clear |

## Verification
A wrong re-arm flag shows up as a missing request, or as a second request one edge after the first, within two cycles of the count change that should have re-armed it. A wrong change stamp in the stall detector shifts the left-turn request by the same number of timer units, so stepping the timer one unit per cycle locates the error to a single cycle. Faults in the balance arithmetic appear only in the window between the bounds, where sweeping weights, offsets and counts across zero, the full range and sign crossings makes them visible on the very next edge.

// File: rtl/psc_pkg.sv
`timescale 1ns/100ps
package psc_pkg;
  typedef enum logic [1:0] {
    PH_GREEN = 2'b00,
    PH_LEFT  = 2'b01,
    PH_PED   = 2'b10,
    PH_IDLE  = 2'b11
  } phase_e;
endpackage

// File: rtl/psc_ctrl_fn.sv
`timescale 1ns/100ps
module psc_ctrl_fn #(
  parameter int CNT_W   = 9,
  parameter int ALPHA_W = 2,
  parameter int F_W     = CNT_W + ALPHA_W + 2
) (
  input  logic [CNT_W-1:0]          own,
  input  logic [CNT_W-1:0]          other,
  input  logic [ALPHA_W-1:0]        alpha,
  input  logic [CNT_W-1:0]          beta,
  output logic signed [F_W-1:0]     f,
  output logic                      f_nonpos
);
  function automatic logic [F_W-1:0] balance(input logic [ALPHA_W-1:0] a,
                                             input logic [CNT_W-1:0] n_own,
                                             input logic [CNT_W-1:0] b,
                                             input logic [CNT_W-1:0] n_oth);
    logic [F_W-1:0] prod;
    prod = F_W'(a) * F_W'(n_own);
    return prod + F_W'(b) - F_W'(n_oth);
  endfunction

  assign f        = signed'(balance(alpha, own, beta, other));
  assign f_nonpos = f[F_W-1] || (f == '0);
endmodule

// File: rtl/psc_stall_det.sv
`timescale 1ns/100ps
module psc_stall_det #(
  parameter int CNT_W   = 9,
  parameter int TMR_W   = 8,
  parameter int STALL_T = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [TMR_W-1:0] tmr,
  output logic             cnt_moved,
  output logic             stalled
);
  localparam logic [TMR_W-1:0] STALL_V = TMR_W'(STALL_T);

  logic [CNT_W-1:0] prev_q;
  logic [TMR_W-1:0] stamp_q;
  logic             tmr_back;

  assign cnt_moved = (cnt != prev_q);
  assign tmr_back  = (tmr < stamp_q);
  assign stalled   = !cnt_moved && !tmr_back && ((tmr - stamp_q) >= STALL_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      stamp_q <= '0;
    end else begin
      prev_q <= cnt;
      if (cnt_moved || tmr_back) stamp_q <= tmr;
    end
  end
endmodule

// File: rtl/psc_rearm.sv
`timescale 1ns/100ps
module psc_rearm #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic             fire,
  output logic             armed
);
  logic [CNT_W-1:0] snap_a_q, snap_b_q;
  logic             traffic_moved;

  assign traffic_moved = (cnt_a != snap_a_q) || (cnt_b != snap_b_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b1;
      snap_a_q <= '0;
      snap_b_q <= '0;
    end else if (fire) begin
      armed    <= 1'b0;
      snap_a_q <= cnt_a;
      snap_b_q <= cnt_b;
    end else if (!armed && traffic_moved) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/phase_switch_ctl.sv
`timescale 1ns/100ps
module phase_switch_ctl
  import psc_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int ALPHA_W = 2,
  parameter int TMR_W   = 8,
  parameter int STALL_T = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_a1,
  input  logic [CNT_W-1:0]   cnt_a2,
  input  logic [TMR_W-1:0]   tmr,
  input  logic [TMR_W-1:0]   min_a1,
  input  logic [TMR_W-1:0]   max_a1,
  input  logic [TMR_W-1:0]   min_a2,
  input  logic [TMR_W-1:0]   max_a2,
  input  logic [TMR_W-1:0]   min_left,
  input  logic [TMR_W-1:0]   max_left,
  input  logic [TMR_W-1:0]   max_ped,
  input  logic [ALPHA_W-1:0] wt_a1,
  input  logic [ALPHA_W-1:0] wt_a2,
  input  logic [CNT_W-1:0]   bias_a1,
  input  logic [CNT_W-1:0]   bias_a2,
  input  logic               fav_arm,
  input  logic [1:0]         phase,
  output logic               sw_req,
  output logic               tmr_clr
);
  localparam int F_W = CNT_W + ALPHA_W + 2;

  logic [CNT_W-1:0]        cnt_arr  [2];
  logic [CNT_W-1:0]        bias_arr [2];
  logic [ALPHA_W-1:0]      wt_arr   [2];
  logic [TMR_W-1:0]        min_arr  [2];
  logic [TMR_W-1:0]        max_arr  [2];
  logic signed [F_W-1:0]   f_arr    [2];
  logic                    fneg_arr [2];

  assign cnt_arr[0]  = cnt_a1;   assign cnt_arr[1]  = cnt_a2;
  assign bias_arr[0] = bias_a1;  assign bias_arr[1] = bias_a2;
  assign wt_arr[0]   = wt_a1;    assign wt_arr[1]   = wt_a2;
  assign min_arr[0]  = min_a1;   assign min_arr[1]  = min_a2;
  assign max_arr[0]  = max_a1;   assign max_arr[1]  = max_a2;

  for (genvar k = 0; k < 2; k++) begin : g_arm
    psc_ctrl_fn #(.CNT_W(CNT_W), .ALPHA_W(ALPHA_W), .F_W(F_W)) u_fn (
      .own      (cnt_arr[k]),
      .other    (cnt_arr[1-k]),
      .alpha    (wt_arr[k]),
      .beta     (bias_arr[k]),
      .f        (f_arr[k]),
      .f_nonpos (fneg_arr[k])
    );
  end

  // Named internal events, also observed by the checker
  phase_e                ph;
  logic [CNT_W-1:0]      fav_cnt;
  logic [TMR_W-1:0]      fav_min, fav_max;
  logic signed [F_W-1:0] f_fav;
  logic                  f_fav_nonpos;
  logic                  cnt_moved, stalled, armed, decide, fire;
  logic                  sw_q;

  assign ph           = phase_e'(phase);
  assign fav_cnt      = cnt_arr[fav_arm];
  assign fav_min      = min_arr[fav_arm];
  assign fav_max      = max_arr[fav_arm];
  assign f_fav        = f_arr[fav_arm];
  assign f_fav_nonpos = fneg_arr[fav_arm];

  psc_stall_det #(.CNT_W(CNT_W), .TMR_W(TMR_W), .STALL_T(STALL_T)) u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (fav_cnt),
    .tmr       (tmr),
    .cnt_moved (cnt_moved),
    .stalled   (stalled)
  );

  always_comb begin
    decide = 1'b0;
    unique case (ph)
      PH_GREEN: begin
        if (tmr < fav_min)       decide = 1'b0;
        else if (tmr >= fav_max) decide = 1'b1;
        else                     decide = (fav_cnt == '0) || f_fav_nonpos;
      end
      PH_LEFT: begin
        if (tmr < min_left)       decide = 1'b0;
        else if (tmr >= max_left) decide = 1'b1;
        else                      decide = stalled;
      end
      PH_PED:  decide = (tmr >= max_ped);
      PH_IDLE: decide = 1'b0;
      default: decide = 1'b0;
    endcase
  end

  assign fire = armed && decide;

  psc_rearm #(.CNT_W(CNT_W)) u_rearm (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_a (cnt_a1),
    .cnt_b (cnt_a2),
    .fire  (fire),
    .armed (armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= fire;
  end

  assign sw_req  = sw_q;
  assign tmr_clr = sw_q;
endmodule

// File: rtl/psc_checks.sv
`timescale 1ns/100ps
module psc_checks #(
  parameter int TMR_W = 8,
  parameter int F_W   = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            phase,
  input logic [TMR_W-1:0]      tmr,
  input logic [TMR_W-1:0]      fav_min,
  input logic [TMR_W-1:0]      fav_max,
  input logic [TMR_W-1:0]      max_ped,
  input logic signed [F_W-1:0] f_fav,
  input logic                  armed,
  input logic                  sw_req
);
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> !sw_req);

  p_hold_after_switch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> !armed);

  p_min_green_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && tmr < fav_min) |=> !sw_req);

  p_max_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && armed && tmr >= fav_max) |=> sw_req);

  p_balance_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && armed && tmr >= fav_min && tmr < fav_max && f_fav <= 0)
      |=> sw_req);

  p_ped_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10 && armed && tmr >= max_ped) |=> sw_req);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11) |=> !sw_req);
endmodule

bind phase_switch_ctl psc_checks #(.TMR_W(TMR_W), .F_W(F_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .phase   (phase),
  .tmr     (tmr),
  .fav_min (fav_min),
  .fav_max (fav_max),
  .max_ped (max_ped),
  .f_fav   (f_fav),
  .armed   (armed),
  .sw_req  (sw_req)
);

// File: tb/phase_switch_ctl_tb.sv
`timescale 1ns/100ps
module phase_switch_ctl_tb;
  localparam int CNT_W = 9, ALPHA_W = 2, TMR_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] cnt_a1 = '0, cnt_a2 = '0, bias_a1 = '0, bias_a2 = '0;
  logic [TMR_W-1:0] tmr = '0, min_a1 = 8'd10, max_a1 = 8'd40, min_a2 = 8'd20, max_a2 = 8'd50;
  logic [TMR_W-1:0] min_left = 8'd5, max_left = 8'd60, max_ped = 8'd20;
  logic [ALPHA_W-1:0] wt_a1 = '0, wt_a2 = '0;
  logic fav_arm = 1'b0;
  logic [1:0] phase = 2'b11;
  logic sw_req, tmr_clr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_switch_ctl u_dut (.*);

  task automatic chk(input bit exp, input string req);
    checks++;
    if (sw_req !== exp || tmr_clr !== exp) begin
      errors++;
      $display("FAIL %s: sw_req=%0b tmr_clr=%0b expected %0b (t=%0d ph=%0b n1=%0d n2=%0d)",
               req, sw_req, tmr_clr, exp, tmr, phase, cnt_a1, cnt_a2);
    end
  endtask

  // Present inputs at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input int t, input int n1, input bit exp, input string req);
    tmr = TMR_W'(t); cnt_a1 = CNT_W'(n1);
    @(posedge clk); @(negedge clk);
    chk(exp, req);
  endtask

  // Idle phase plus a count wiggle re-arms the controller without requesting (R8, R10)
  task automatic rearm();
    logic [CNT_W-1:0] keep;
    keep = cnt_a1;
    phase = 2'b11; tmr = '0; cnt_a1 = keep ^ 1'b1;
    @(posedge clk); @(negedge clk);
    chk(1'b0, "R8");
    cnt_a1 = keep;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit exp_green(int n_own, int n_oth, int a, int b, int t, int rmin, int rmax);
    int bal;
    bal = a * n_own + b - n_oth;
    if (t < rmin) return 1'b0;
    if (t >= rmax) return 1'b1;
    return (n_own == 0) || (bal <= 0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nv[5];
    int bv[3];
    nv = '{0, 1, 5, 100, 511};
    bv = '{0, 7, 511};
    // R11: reset state
    repeat (3) @(negedge clk);
    chk(1'b0, "R11 in reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(1'b0, "R11 after reset");

    // R1-R4 sweep: green phase, both arms, weights, offsets, counts, timer around bounds
    for (int fa = 0; fa < 2; fa++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int a = 0; a < 4; a++)
            for (int b = 0; b < 3; b++)
              for (int q = 0; q < 5; q++) begin
                int rmin, rmax, tt, own, oth;
                rmin = fa ? 20 : 10; rmax = fa ? 50 : 40;
                case (q)
                  0: tt = rmin - 1;
                  1: tt = rmin;
                  2: tt = rmax - 1;
                  3: tt = rmax;
                  default: tt = rmax + 5;
                endcase
                cnt_a2 = CNT_W'(nv[j]); cnt_a1 = CNT_W'(nv[i]);
                rearm();
                fav_arm = fa[0];
                wt_a1 = ALPHA_W'(a); wt_a2 = ALPHA_W'(a);
                bias_a1 = CNT_W'(bv[b]); bias_a2 = CNT_W'(bv[b]);
                own = fa ? nv[j] : nv[i]; oth = fa ? nv[i] : nv[j];
                phase = 2'b00;
                step(tt, nv[i], exp_green(own, oth, a, b ? bv[b] : 0, tt, rmin, rmax),
                     q == 0 ? "R2" : (q >= 3 ? "R3" : "R4 R1"));
              end

    // R6: left turn, count held from T=0, request exactly at T=5
    fav_arm = 1'b0; cnt_a2 = 9'd3; cnt_a1 = 9'd7; min_left = 8'd5; max_left = 8'd60;
    rearm(); phase = 2'b01;
    for (int t = 0; t < 5; t++) step(t, 7, 1'b0, "R6 not yet stalled");
    step(5, 7, 1'b1, "R6 stall reached");
    // R6: count change at T=3 restarts the stall window, request at T=8
    rearm(); phase = 2'b01;
    for (int t = 0; t < 3; t++) step(t, 7, 1'b0, "R6 before change");
    for (int t = 3; t < 8; t++) step(t, 8, 1'b0, "R6 window restarted");
    step(8, 8, 1'b1, "R6 stall after change");
    // R5: stall present but below min_left, held until T=10
    min_left = 8'd10;
    rearm(); phase = 2'b01;
    for (int t = 0; t < 10; t++) step(t, 8, 1'b0, "R5 below min_left");
    step(10, 8, 1'b1, "R5 min_left reached with stall");
    // R5: counts keep moving, forced at max_left
    rearm(); phase = 2'b01;
    step(58, 20, 1'b0, "R5 moving queue");
    step(59, 21, 1'b0, "R5 moving queue");
    step(60, 22, 1'b1, "R5 forced at max_left");

    // R7: pedestrian sweep around max_ped
    for (int t = 15; t < 24; t++) begin
      rearm(); phase = 2'b10;
      step(t, cnt_a1, t >= 20, "R7");
    end

    // R8: idle phase with every trigger present
    rearm(); phase = 2'b11;
    step(255, 0, 1'b0, "R8 idle");
    step(255, 0, 1'b0, "R8 idle");

    // R9/R10: single pulse, silence while counts hold, re-arm on change
    cnt_a1 = 9'd5; cnt_a2 = 9'd5; wt_a1 = 2'd1; bias_a1 = 9'd0; fav_arm = 1'b0;
    rearm(); phase = 2'b00;
    step(40, 5, 1'b1, "R9 request");
    step(40, 5, 1'b0, "R9 single cycle");
    step(40, 5, 1'b0, "R10 held");
    step(40, 5, 1'b0, "R10 held");
    cnt_a2 = 9'd6;
    step(40, 5, 1'b0, "R10 re-arm edge");
    step(40, 5, 1'b1, "R10 request after re-arm");
    step(40, 5, 1'b0, "R10 held again");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule